// File: doc/BRIEF.md
# Per-Thread Partitioned Jump Page Translation

This block forms the fetch target of a direct jump for a four-thread barrel core. A jump does not add its immediate to the program counter; instead the low twelve immediate bits overwrite the page-offset part of the PC. Four further immediate bits above the offset decide what happens to the page part. When they are zero the jump stays inside the page the thread is already running in. That page is known to be valid, so no lookup is made and no fault is possible. When they are nonzero they are used directly as an index into a small table of sixteen translation slots, and the slot supplies the physical page number.

The slots are arranged in groups. Every thread owns a group-select register, and a thread's cross-page jumps only ever see the group its register names. The lookup is a plain indexed read, not an associative compare. Supervisor logic fills slots and group-select registers through two write ports. A slot whose valid bit is clear produces a one-cycle fault pulse instead of a target, and the thread's PC is not redirected. Results come out one cycle after the jump is presented.

Top module: `jxl_jump_xlate`

## Requirements
- R1: After reset every group-select register is 0, every slot is invalid, and tgt_valid and fault are low.
- R2: A jump presented with jmp_valid high in cycle N yields exactly one of tgt_valid or fault in cycle N+1. Without a jump both stay low.
- R3: Bits [11:0] of tgt_pc equal jmp_imm[11:0] for every valid target.
- R4: When jmp_imm[15:12] is zero, tgt_pc[31:12] equals cur_pc[31:12] and tgt_xlat is low. No fault is raised, whatever the slot contents are.
- R5: When jmp_imm[15:12] is nonzero, the slot at index jmp_imm[15:12] of the group named by the jumping thread's group-select register is read. If that slot is valid, tgt_pc[31:12] is its page number and tgt_xlat is high.
- R6: When the slot read for R5 is invalid, fault pulses for one cycle, tgt_valid stays low, and res_tid carries the jumping thread.
- R7: A group-select write changes only the register of thread tag_tid. The other threads keep resolving through their own groups.
- R8: A slot write stores ent_ppn and ent_vld at (ent_grp, ent_idx). Writing ent_vld low makes later jumps to that slot fault.
- R9: A lookup in the same cycle as a write to the slot it reads, or to its thread's group-select register, sees the contents from before that write.
- R10: res_tid equals the jmp_tid of the jump that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jmp_valid | input | 1 | A jump is presented this cycle |
| jmp_tid | input | 2 | Thread issuing the jump |
| jmp_imm | input | 16 | Jump immediate: [15:12] slot index, [11:0] page offset |
| cur_pc | input | 32 | Current PC of the jumping thread |
| tag_we | input | 1 | Group-select register write enable |
| tag_tid | input | 2 | Thread whose group-select register is written |
| tag_grp | input | 2 | New group number |
| ent_we | input | 1 | Slot write enable |
| ent_grp | input | 2 | Group of the slot written |
| ent_idx | input | 4 | Index of the slot written |
| ent_ppn | input | 20 | Physical page number written |
| ent_vld | input | 1 | Valid bit written |
| tgt_valid | output | 1 | Target is available this cycle |
| tgt_pc | output | 32 | Jump target |
| tgt_xlat | output | 1 | Target page came from a slot |
| fault | output | 1 | One-cycle pulse: invalid slot was indexed |
| res_tid | output | 2 | Thread the result or fault belongs to |

## Verification
The bench targets index zero with every slot invalid. A design that looked up slot 0 there would fault on jumps that should stay in the current page. Threads are given different group-select values so that their jumps with the same index hit different slots. A design that shared one select register, or decoded the wrong thread's register, would return another group's page. Writes to a slot or a select register are made in the same cycle as a jump that reads them, and the result must come from the old contents. Bypassed write data would show the new page one cycle too early. A slot is filled and then invalidated, and the next jump to it must fault. A design that ignored the valid bit, or that redirected the PC on a fault, would return a target instead.

// File: rtl/jxl_pkg.sv
package jxl_pkg;

    localparam int THREADS = 4;
    localparam int TID_W   = $clog2(THREADS);
    localparam int GROUPS  = 4;
    localparam int GRP_W   = $clog2(GROUPS);
    localparam int IDX_W   = 4;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int SLOTS   = GROUPS * ENTRIES;
    localparam int SLOT_W  = GRP_W + IDX_W;
    localparam int OFF_W   = 12;
    localparam int IMM_W   = IDX_W + OFF_W;
    localparam int PA_W    = 32;
    localparam int PPN_W   = PA_W - OFF_W;

    typedef struct packed {
        logic             vld;
        logic [PPN_W-1:0] ppn;
    } xl_slot_t;

    typedef enum logic [1:0] {
        JK_NONE  = 2'd0,
        JK_LOCAL = 2'd1,
        JK_XLAT  = 2'd2,
        JK_FAULT = 2'd3
    } jump_kind_e;

    typedef struct packed {
        jump_kind_e       kind;
        logic [TID_W-1:0] tid;
        logic [PA_W-1:0]  pc;
    } jump_res_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [IMM_W-1:0] imm);
        return imm[IMM_W-1:OFF_W];
    endfunction

    function automatic logic [OFF_W-1:0] off_of(input logic [IMM_W-1:0] imm);
        return imm[OFF_W-1:0];
    endfunction

    function automatic logic stays_local(input logic [IMM_W-1:0] imm);
        return idx_of(imm) == '0;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [GRP_W-1:0] grp,
                                                  input logic [IDX_W-1:0] idx);
        return {grp, idx};
    endfunction

endpackage

// File: rtl/jxl_tag_bank.sv
module jxl_tag_bank
    import jxl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [TID_W-1:0] wr_tid,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [TID_W-1:0] rd_tid,
    output logic [GRP_W-1:0] rd_grp
);

    logic [GRP_W-1:0] tag_q [THREADS];

    for (genvar t = 0; t < THREADS; t++) begin : g_thread
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[t] <= '0;
            end else if (we && wr_tid == TID_W'(t)) begin
                tag_q[t] <= wr_grp;
            end
        end
    end

    assign rd_grp = tag_q[rd_tid];

endmodule

// File: rtl/jxl_slot_array.sv
module jxl_slot_array
    import jxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] wr_slot,
    input  xl_slot_t          wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output xl_slot_t          rd_data
);

    xl_slot_t mem_q [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SLOTS; s++) begin
                mem_q[s] <= '0;
            end
        end else if (we) begin
            mem_q[wr_slot] <= wr_data;
        end
    end

    // Read sees pre-write contents: the write lands at the same edge as the result register
    assign rd_data = mem_q[rd_slot];

endmodule

// File: rtl/jxl_target_form.sv
module jxl_target_form
    import jxl_pkg::*;
(
    input  logic [TID_W-1:0] tid,
    input  logic [IMM_W-1:0] imm,
    input  logic [PA_W-1:0]  pc,
    input  xl_slot_t         slot,
    output jump_res_t        res
);

    always_comb begin
        res.tid = tid;
        if (stays_local(imm)) begin
            res.kind = JK_LOCAL;
            res.pc   = {pc[PA_W-1:OFF_W], off_of(imm)};
        end else if (slot.vld) begin
            res.kind = JK_XLAT;
            res.pc   = {slot.ppn, off_of(imm)};
        end else begin
            res.kind = JK_FAULT;
            res.pc   = pc;
        end
    end

endmodule

// File: rtl/jxl_jump_xlate.sv
module jxl_jump_xlate
    import jxl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             jmp_valid,
    input  logic [TID_W-1:0] jmp_tid,
    input  logic [IMM_W-1:0] jmp_imm,
    input  logic [PA_W-1:0]  cur_pc,
    input  logic             tag_we,
    input  logic [TID_W-1:0] tag_tid,
    input  logic [GRP_W-1:0] tag_grp,
    input  logic             ent_we,
    input  logic [GRP_W-1:0] ent_grp,
    input  logic [IDX_W-1:0] ent_idx,
    input  logic [PPN_W-1:0] ent_ppn,
    input  logic             ent_vld,
    output logic             tgt_valid,
    output logic [PA_W-1:0]  tgt_pc,
    output logic             tgt_xlat,
    output logic             fault,
    output logic [TID_W-1:0] res_tid
);

    logic [GRP_W-1:0] cur_grp;
    xl_slot_t         rd_slot;
    xl_slot_t         wr_slot_data;
    jump_res_t        res_nxt;
    jump_res_t        res_q;

    jxl_tag_bank u_tags (
        .clk    (clk),
        .rst    (rst),
        .we     (tag_we),
        .wr_tid (tag_tid),
        .wr_grp (tag_grp),
        .rd_tid (jmp_tid),
        .rd_grp (cur_grp)
    );

    assign wr_slot_data = '{vld: ent_vld, ppn: ent_ppn};

    jxl_slot_array u_slots (
        .clk     (clk),
        .rst     (rst),
        .we      (ent_we),
        .wr_slot (slot_of(ent_grp, ent_idx)),
        .wr_data (wr_slot_data),
        .rd_slot (slot_of(cur_grp, idx_of(jmp_imm))),
        .rd_data (rd_slot)
    );

    jxl_target_form u_form (
        .tid  (jmp_tid),
        .imm  (jmp_imm),
        .pc   (cur_pc),
        .slot (rd_slot),
        .res  (res_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (jmp_valid) begin
            res_q <= res_nxt;
        end else begin
            res_q.kind <= JK_NONE;
        end
    end

    assign tgt_valid = (res_q.kind == JK_LOCAL) || (res_q.kind == JK_XLAT);
    assign tgt_xlat  = (res_q.kind == JK_XLAT);
    assign fault     = (res_q.kind == JK_FAULT);
    assign tgt_pc    = res_q.pc;
    assign res_tid   = res_q.tid;

endmodule

// File: rtl/jxl_jump_xlate_chk.sv
module jxl_jump_xlate_chk
    import jxl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             jmp_valid,
    input logic [TID_W-1:0] jmp_tid,
    input logic [IMM_W-1:0] jmp_imm,
    input logic [PA_W-1:0]  cur_pc,
    input logic             tgt_valid,
    input logic [PA_W-1:0]  tgt_pc,
    input logic             tgt_xlat,
    input logic             fault,
    input logic [TID_W-1:0] res_tid
);

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !jmp_valid |=> (!tgt_valid && !fault));                                      // R2

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        jmp_valid |=> (tgt_valid != fault));                                         // R2

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        jmp_valid |=> (!tgt_valid || tgt_pc[OFF_W-1:0] == $past(jmp_imm[OFF_W-1:0]))); // R3

    AST_LOCAL_PAGE: assert property (@(posedge clk) disable iff (rst)
        (jmp_valid && jmp_imm[IMM_W-1:OFF_W] == '0) |=>
            (tgt_valid && !tgt_xlat && tgt_pc[PA_W-1:OFF_W] == $past(cur_pc[PA_W-1:OFF_W]))); // R4

    AST_REMOTE_KIND: assert property (@(posedge clk) disable iff (rst)
        (jmp_valid && jmp_imm[IMM_W-1:OFF_W] != '0) |=> (tgt_valid == tgt_xlat));    // R5

    AST_RESULT_TID: assert property (@(posedge clk) disable iff (rst)
        jmp_valid |=> (res_tid == $past(jmp_tid)));                                   // R10

endmodule

bind jxl_jump_xlate jxl_jump_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .jmp_valid (jmp_valid),
    .jmp_tid   (jmp_tid),
    .jmp_imm   (jmp_imm),
    .cur_pc    (cur_pc),
    .tgt_valid (tgt_valid),
    .tgt_pc    (tgt_pc),
    .tgt_xlat  (tgt_xlat),
    .fault     (fault),
    .res_tid   (res_tid)
);

// File: tb/sim_jxl_jump_xlate.sv
module sim_jxl_jump_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        jmp_valid = 1'b0;
    logic [1:0]  jmp_tid = '0;
    logic [15:0] jmp_imm = '0;
    logic [31:0] cur_pc = '0;
    logic        tag_we = 1'b0;
    logic [1:0]  tag_tid = '0;
    logic [1:0]  tag_grp = '0;
    logic        ent_we = 1'b0;
    logic [1:0]  ent_grp = '0;
    logic [3:0]  ent_idx = '0;
    logic [19:0] ent_ppn = '0;
    logic        ent_vld = 1'b0;
    logic        tgt_valid;
    logic [31:0] tgt_pc;
    logic        tgt_xlat;
    logic        fault;
    logic [1:0]  res_tid;

    always #2 clk = ~clk;

    jxl_jump_xlate u0 (.*);

    // reference state
    int          m_tag [4];
    logic [19:0] m_ppn [4][16];
    bit          m_vld [4][16];
    bit          e_valid, e_fault, e_xlat;
    logic [31:0] e_pc;
    logic [1:0]  e_tid;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string phase  = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s (phase %s): actual %0h expected %0h", req, what, phase, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [3:0] idx;
        int g;
        e_valid = 0; e_fault = 0; e_xlat = 0; e_pc = '0; e_tid = jmp_tid;
        idx = jmp_imm[15:12];
        if (jmp_valid) begin
            if (idx == 0) begin
                e_valid = 1;
                e_pc = {cur_pc[31:12], jmp_imm[11:0]};
            end else begin
                g = m_tag[jmp_tid];
                if (m_vld[g][idx]) begin
                    e_valid = 1; e_xlat = 1;
                    e_pc = {m_ppn[g][idx], jmp_imm[11:0]};
                end else begin
                    e_fault = 1;
                end
            end
        end
        // updates after the read: same-cycle writes are not seen (R9)
        if (tag_we) m_tag[tag_tid] = int'(tag_grp);
        if (ent_we) begin
            m_ppn[ent_grp][ent_idx] = ent_ppn;
            m_vld[ent_grp][ent_idx] = ent_vld;
        end
    endtask

    task automatic compare();
        string pg;
        pg = (jmp_imm[15:12] == 0) ? "R4" : "R5";
        chk(tgt_valid == e_valid, "R2", "tgt_valid", tgt_valid, e_valid);
        chk(fault == e_fault, "R6", "fault", fault, e_fault);
        if (e_valid) begin
            chk(tgt_pc[11:0] == e_pc[11:0], "R3", "offset", tgt_pc[11:0], e_pc[11:0]);
            chk(tgt_pc[31:12] == e_pc[31:12], pg, "page", tgt_pc[31:12], e_pc[31:12]);
            chk(tgt_xlat == e_xlat, pg, "tgt_xlat", tgt_xlat, e_xlat);
        end
        if (e_valid || e_fault)
            chk(res_tid == e_tid, "R10", "res_tid", res_tid, e_tid);
    endtask

    // one clock: inputs held from the previous negedge, results sampled at the next negedge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        jmp_valid = 0; tag_we = 0; ent_we = 0;
    endtask

    task automatic set_jump(input logic [1:0] t, input logic [15:0] imm, input logic [31:0] pc);
        jmp_valid = 1; jmp_tid = t; jmp_imm = imm; cur_pc = pc;
    endtask

    task automatic set_ent(input logic [1:0] g, input logic [3:0] i,
                           input logic [19:0] p, input bit v);
        ent_we = 1; ent_grp = g; ent_idx = i; ent_ppn = p; ent_vld = v;
    endtask

    task automatic set_tag(input logic [1:0] t, input logic [1:0] g);
        tag_we = 1; tag_tid = t; tag_grp = g;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        for (int t = 0; t < 4; t++) m_tag[t] = 0;
        for (int g = 0; g < 4; g++)
            for (int i = 0; i < 16; i++) begin m_ppn[g][i] = '0; m_vld[g][i] = 0; end

        // R1: reset state at the ports
        repeat (3) @(negedge clk);
        chk(!tgt_valid && !fault, "R1", "outputs in reset", {tgt_valid, fault}, 0);
        rst = 0;

        // R1: every slot starts invalid, so any cross-page jump faults (R6)
        for (int t = 0; t < 4; t++) begin
            set_jump(2'(t), {4'(t + 3), 12'h5a0}, 32'h1234_5000);
            step();
        end
        step();

        // R4: same-page jumps never fault, even with all slots invalid
        phase = "R4";
        set_jump(2'd0, 16'h0abc, 32'hdead_b123); step();
        set_jump(2'd3, 16'h0000, 32'hffff_ffff); step();
        set_jump(2'd1, 16'h0fff, 32'h0000_0000); step();

        // R8: fill group 0 and group 1, then translate through group 0 (R5)
        phase = "R8";
        for (int i = 1; i < 16; i++) begin
            set_ent(2'd0, 4'(i), 20'h10000 + 20'(i), 1); step();
            set_ent(2'd1, 4'(i), 20'h20000 + 20'(i), 1); step();
        end
        phase = "R5";
        for (int t = 0; t < 4; t++) begin
            set_jump(2'(t), {4'(t + 1), 12'h3c4}, 32'h7777_7000); step();
        end
        set_jump(2'd2, 16'hf001, 32'h0); step();

        // R7: thread 2 moves to group 1; others stay on group 0
        phase = "R7";
        set_tag(2'd2, 2'd1); step();
        for (int t = 0; t < 4; t++) begin
            set_jump(2'(t), 16'h7010, 32'h0); step();
        end
        // thread 3 moves to empty group 3: its jumps fault, thread 2 still translates
        set_tag(2'd3, 2'd3); step();
        set_jump(2'd3, 16'h7010, 32'h0); step();
        set_jump(2'd2, 16'h7010, 32'h0); step();

        // R9: write and lookup of the same slot in one cycle returns the old page
        phase = "R9";
        set_ent(2'd0, 4'd5, 20'habcde, 1);
        set_jump(2'd0, 16'h5111, 32'h0); step();
        set_jump(2'd0, 16'h5111, 32'h0); step();
        // tag write in the same cycle as a jump of that thread uses the old group
        set_tag(2'd0, 2'd1);
        set_jump(2'd0, 16'h5222, 32'h0); step();
        set_jump(2'd0, 16'h5222, 32'h0); step();

        // R8: invalidating a slot makes the next jump to it fault (R6)
        phase = "R8";
        set_ent(2'd1, 4'd5, 20'h0, 0); step();
        set_jump(2'd0, 16'h5333, 32'h0); step();
        step();

        // mixed traffic
        phase = "R5";
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[0]) set_jump(r[2:1], (r[5:3] == 0) ? {4'h0, r[17:6]} : {r[9:6], r[21:10]},
                               $urandom);
            if (r[23:22] == 0) set_ent(r[25:24], r[29:26], 20'($urandom), r[30]);
            if (r[31:28] == 4'hf) set_tag(r[25:24], r[27:26]);
            step();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule